// File: doc/BRIEF.md
# Configurable Slice Storage Bank

This block is a bank of eight single-bit storage elements arranged as four lanes, A to D. Each lane has one primary and one secondary element. A configuration word controls the whole bank, and the same settings apply to every element. The bank-wide settings are:

- flip-flop or latch operation;
- synchronous or asynchronous set/reset;
- clock polarity;
- whether the clock-enable pin is used;
- whether the set/reset pin is used.

Three per-element bits describe each element individually:

- whether the element is set-type or reset-type;
- the value it loads on set/reset;
- the value it loads on global init.

Each element's data input comes from a two-way mux. For primary elements the choice is between two candidate pins. For secondary elements the choice is between the lane's five-input LUT output and its bypass pin.

The polarity of several encodings depends on latch mode. The init-value encoding and the clock-polarity bit both reverse when the bank runs as latches. In latch mode only the primary elements operate, and the secondary outputs read zero.

Top module: `slice_store_bank`

## Requirements
- R1: While rst_ni is low or ginit_i is high, each element asynchronously holds its init load. In flip-flop mode the init load is the inverse of its init bit. In latch mode it equals its init bit.
- R2: Global init has priority over set/reset and over data. When ginit_i falls while an asynchronous set/reset is still active, the next effective clock edge loads the set/reset value.
- R3: The set/reset load of an element is its sr_val bit when its set_type bit is 1, and the inverse of its sr_val bit when its set_type bit is 0.
- R4: With sync_sr=1, set/reset takes effect only at an effective clock edge. With sync_sr=0, it takes effect at once.
- R5: With sr_used=0, sr_i has no effect, and elements keep following data and clock enable.
- R6: With ce_used=0, every effective edge captures data whatever ce_i is. With ce_used=1 and ce_i low, the elements hold.
- R7: A synchronous set/reset has priority over clock enable and data.
- R8: In flip-flop mode, clk_inv=0 captures on the rising edge of clk_i and clk_inv=1 captures on the falling edge.
- R9: In latch mode, a primary element is transparent while the gate is active and ce is high, and holds otherwise. The gate is active while clk_i is high when clk_inv=1, and while clk_i is low when clk_inv=0.
- R10: In latch mode, q_o[7:4] (the secondary elements) read 0.
- R11: Each secondary element takes lut5_i of its lane when its sec_sel bit is 0, and byp_i of its lane when the bit is 1.
- R12: Each primary element takes pri_a_i of its lane when its pri_sel bit is 0, and pri_b_i of its lane when the bit is 1.
- R13: Layout of cfg_i, from bit 0 upward:
  - latch_mode[0], sync_sr[1], clk_inv[2], ce_used[3], sr_used[4];
  - set_type[12:5], sr_val[20:13], init_val[28:21];
  - sec_sel[32:29], pri_sel[36:33].

  In every per-element field, bit e is element e. Elements 0..3 are primary A..D and elements 4..7 are secondary A..D. q_o uses the same element order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, also the latch gate |
| rst_ni | input | 1 | Active-low reset, loads the init values |
| ce_i | input | 1 | Clock enable |
| sr_i | input | 1 | Set/reset |
| ginit_i | input | 1 | Global init strobe |
| cfg_i | input | 37 | Configuration word |
| pri_a_i | input | 4 | Primary data candidate 0, one bit per lane |
| pri_b_i | input | 4 | Primary data candidate 1, one bit per lane |
| lut5_i | input | 4 | Five-input LUT output, one bit per lane |
| byp_i | input | 4 | Bypass pin, one bit per lane |
| q_o | output | 8 | Element outputs, primaries in bits 3..0 and secondaries in bits 7..4 |

## Verification
Set/reset and global init can fall in the same cycle. So can set/reset and a clock-enabled data capture. The bench raises ginit_i and an asynchronous sr_i together and expects the init load. It then drops ginit_i while sr_i stays high, and expects the set/reset load only after the next edge. For the synchronous case, sr_i and ce_i are driven high together with data that differs from the set/reset load, and the captured value must be the set/reset load.

// File: rtl/sbank_pkg.sv
package sbank_pkg;
  localparam int unsigned LANES = 4;
  localparam int unsigned ELEMS = 2 * LANES;

  typedef struct packed {
    logic [LANES-1:0] pri_sel;
    logic [LANES-1:0] sec_sel;
    logic [ELEMS-1:0] init_val;
    logic [ELEMS-1:0] sr_val;
    logic [ELEMS-1:0] set_type;
    logic             sr_used;
    logic             ce_used;
    logic             clk_inv;
    logic             sync_sr;
    logic             latch_mode;
  } sbank_cfg_t;

  localparam int unsigned CFG_W = $bits(sbank_cfg_t);
endpackage

// File: rtl/sbank_ctrl.sv
module sbank_ctrl
  import sbank_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ce_i,
  input  logic             sr_i,
  input  logic             ginit_i,
  input  logic             latch_mode_i,
  input  logic             sync_sr_i,
  input  logic             clk_inv_i,
  input  logic             ce_used_i,
  input  logic             sr_used_i,
  input  logic [ELEMS-1:0] set_type_i,
  input  logic [ELEMS-1:0] sr_val_i,
  input  logic [ELEMS-1:0] init_val_i,
  output logic             eclk_o,
  output logic             arst_o,
  output logic             sync_sr_o,
  output logic             ce_o,
  output logic [ELEMS-1:0] arst_val_o,
  output logic [ELEMS-1:0] sr_load_o
);
  logic init_hit;
  logic sr_act;
  logic clk_flip;

  // clock-polarity meaning reverses in latch mode
  assign clk_flip  = latch_mode_i ? ~clk_inv_i : clk_inv_i;
  assign eclk_o    = clk_i ^ clk_flip;
  assign sr_act    = sr_used_i & sr_i;
  assign ce_o      = ~ce_used_i | ce_i;
  assign init_hit  = ~rst_ni | ginit_i;
  assign arst_o    = init_hit | (sr_act & ~sync_sr_i);
  assign sync_sr_o = sr_act & sync_sr_i;

  for (genvar e = 0; e < ELEMS; e++) begin : g_elem
    logic init_load;
    assign init_load     = latch_mode_i ? init_val_i[e] : ~init_val_i[e];
    assign sr_load_o[e]  = set_type_i[e] ? sr_val_i[e] : ~sr_val_i[e];
    assign arst_val_o[e] = init_hit ? init_load : sr_load_o[e];
  end
endmodule

// File: rtl/sbank_ff.sv
module sbank_ff (
  input  logic clk_i,
  input  logic arst_i,
  input  logic arst_val_i,
  input  logic sync_sr_i,
  input  logic sr_val_i,
  input  logic ce_i,
  input  logic d_i,
  output logic q_o
);
  always_ff @(posedge clk_i or posedge arst_i) begin
    if (arst_i)         q_o <= arst_val_i;
    else if (sync_sr_i) q_o <= sr_val_i;
    else if (ce_i)      q_o <= d_i;
  end
endmodule

// File: rtl/sbank_latch.sv
module sbank_latch (
  input  logic gate_i,
  input  logic arst_i,
  input  logic arst_val_i,
  input  logic sync_sr_i,
  input  logic sr_val_i,
  input  logic ce_i,
  input  logic d_i,
  output logic q_o
);
  always_latch begin
    if (arst_i)                  q_o <= arst_val_i;
    else if (gate_i && sync_sr_i) q_o <= sr_val_i;
    else if (gate_i && ce_i)      q_o <= d_i;
  end
endmodule

// File: rtl/sbank_lane.sv
module sbank_lane (
  input  logic eclk_i,
  input  logic arst_i,
  input  logic sync_sr_i,
  input  logic ce_i,
  input  logic latch_i,
  input  logic pri_arst_val_i,
  input  logic sec_arst_val_i,
  input  logic pri_sr_val_i,
  input  logic sec_sr_val_i,
  input  logic pri_a_i,
  input  logic pri_b_i,
  input  logic pri_sel_i,
  input  logic lut5_i,
  input  logic byp_i,
  input  logic sec_sel_i,
  output logic pri_q_o,
  output logic sec_q_o
);
  logic pri_d, sec_d;
  logic pri_ff_q, pri_lat_q, sec_ff_q;

  assign pri_d = pri_sel_i ? pri_b_i : pri_a_i;
  assign sec_d = sec_sel_i ? byp_i : lut5_i;

  sbank_ff u_pri_ff (
    .clk_i(eclk_i), .arst_i(arst_i), .arst_val_i(pri_arst_val_i),
    .sync_sr_i(sync_sr_i), .sr_val_i(pri_sr_val_i), .ce_i(ce_i),
    .d_i(pri_d), .q_o(pri_ff_q)
  );

  sbank_latch u_pri_lat (
    .gate_i(eclk_i), .arst_i(arst_i), .arst_val_i(pri_arst_val_i),
    .sync_sr_i(sync_sr_i), .sr_val_i(pri_sr_val_i), .ce_i(ce_i),
    .d_i(pri_d), .q_o(pri_lat_q)
  );

  sbank_ff u_sec_ff (
    .clk_i(eclk_i), .arst_i(arst_i), .arst_val_i(sec_arst_val_i),
    .sync_sr_i(sync_sr_i), .sr_val_i(sec_sr_val_i), .ce_i(ce_i),
    .d_i(sec_d), .q_o(sec_ff_q)
  );

  assign pri_q_o = latch_i ? pri_lat_q : pri_ff_q;
  // secondary elements are not usable in latch mode
  assign sec_q_o = latch_i ? 1'b0 : sec_ff_q;
endmodule

// File: rtl/slice_store_bank.sv
module slice_store_bank
  import sbank_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ce_i,
  input  logic             sr_i,
  input  logic             ginit_i,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic [LANES-1:0] pri_a_i,
  input  logic [LANES-1:0] pri_b_i,
  input  logic [LANES-1:0] lut5_i,
  input  logic [LANES-1:0] byp_i,
  output logic [ELEMS-1:0] q_o
);
  sbank_cfg_t       cfg;
  logic             eclk, arst, sync_sr, ce_eff;
  logic [ELEMS-1:0] arst_val, sr_load;

  assign cfg = sbank_cfg_t'(cfg_i);

  sbank_ctrl u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .ce_i(ce_i), .sr_i(sr_i), .ginit_i(ginit_i),
    .latch_mode_i(cfg.latch_mode), .sync_sr_i(cfg.sync_sr), .clk_inv_i(cfg.clk_inv),
    .ce_used_i(cfg.ce_used), .sr_used_i(cfg.sr_used), .set_type_i(cfg.set_type),
    .sr_val_i(cfg.sr_val), .init_val_i(cfg.init_val),
    .eclk_o(eclk), .arst_o(arst), .sync_sr_o(sync_sr), .ce_o(ce_eff),
    .arst_val_o(arst_val), .sr_load_o(sr_load)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    sbank_lane u_lane (
      .eclk_i(eclk), .arst_i(arst), .sync_sr_i(sync_sr), .ce_i(ce_eff),
      .latch_i(cfg.latch_mode),
      .pri_arst_val_i(arst_val[l]), .sec_arst_val_i(arst_val[l+LANES]),
      .pri_sr_val_i(sr_load[l]), .sec_sr_val_i(sr_load[l+LANES]),
      .pri_a_i(pri_a_i[l]), .pri_b_i(pri_b_i[l]), .pri_sel_i(cfg.pri_sel[l]),
      .lut5_i(lut5_i[l]), .byp_i(byp_i[l]), .sec_sel_i(cfg.sec_sel[l]),
      .pri_q_o(q_o[l]), .sec_q_o(q_o[l+LANES])
    );
  end
endmodule

// File: rtl/sbank_chk.sv
module sbank_chk
  import sbank_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ce_i,
  input logic             sr_i,
  input logic             ginit_i,
  input logic [CFG_W-1:0] cfg_i,
  input logic [ELEMS-1:0] q_o
);
  sbank_cfg_t c;
  logic [ELEMS-1:0] exp_sr;
  logic [ELEMS-1:0] exp_init;
  assign c        = sbank_cfg_t'(cfg_i);
  assign exp_sr   = ~(c.set_type ^ c.sr_val);
  assign exp_init = c.latch_mode ? c.init_val : ~c.init_val;

  a_r1_init_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ginit_i && $past(ginit_i) && $stable(cfg_i)) |-> (q_o[LANES-1:0] == exp_init[LANES-1:0]));

  a_r10_sec_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c.latch_mode |-> (q_o[ELEMS-1:LANES] == '0));

  a_r6_ce_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ginit_i && !c.latch_mode && !c.clk_inv && c.ce_used && !ce_i && !(c.sr_used && sr_i))
    |=> ($stable(q_o) || ginit_i || (c.sr_used && sr_i) || !$stable(cfg_i)));

  a_r7_sync_sr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ginit_i && !c.latch_mode && !c.clk_inv && c.sync_sr && c.sr_used && sr_i)
    |=> ((q_o == exp_sr) || ginit_i || !$stable(cfg_i)));
endmodule

bind slice_store_bank sbank_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ce_i(ce_i), .sr_i(sr_i),
  .ginit_i(ginit_i), .cfg_i(cfg_i), .q_o(q_o)
);

// File: tb/tb_slice_store_bank.sv
`timescale 1ns/1ps
module tb_slice_store_bank;
  logic        clk = 1'b0;
  logic        rst_ni, ce_i, sr_i, ginit_i;
  logic [36:0] cfg_i;
  logic [3:0]  pri_a_i, pri_b_i, lut5_i, byp_i;
  logic [7:0]  q_o;
  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  slice_store_bank dut (
    .clk_i(clk), .rst_ni(rst_ni), .ce_i(ce_i), .sr_i(sr_i), .ginit_i(ginit_i),
    .cfg_i(cfg_i), .pri_a_i(pri_a_i), .pri_b_i(pri_b_i), .lut5_i(lut5_i),
    .byp_i(byp_i), .q_o(q_o)
  );

  // R13 layout
  function automatic logic [36:0] mk(input logic lat, input logic syn, input logic cinv,
    input logic ceu, input logic sru, input logic [7:0] st, input logic [7:0] sv,
    input logic [7:0] iv, input logic [3:0] ss, input logic [3:0] ps);
    return {ps, ss, iv, sv, st, sru, ceu, cinv, syn, lat};
  endfunction

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_init(input logic [36:0] c);
    ce_i = 1'b0; sr_i = 1'b0;
    cfg_i = c; ginit_i = 1'b1;
    tick; tick;
    ginit_i = 1'b0;
    tick;
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run;
  end

  initial begin
    rst_ni = 1'b0; ce_i = 1'b0; sr_i = 1'b0; ginit_i = 1'b0; cfg_i = '0;
    pri_a_i = '0; pri_b_i = '0; lut5_i = '0; byp_i = '0;
    #13;
    chk("R1 reset", q_o, 8'hFF);
    tick; rst_ni = 1'b1;
    tick;

    // R1, R10: init encoding sweep in both modes
    for (int lat = 0; lat < 2; lat++) begin
      for (int iv = 0; iv < 256; iv++) begin
        do_init(mk(lat[0], 1'b1, lat[0], 1'b1, 1'b0, 8'h00, 8'h00, iv[7:0], 4'h0, 4'h0));
        if (lat == 1) chk("R1/R10 latch init", q_o, {4'h0, iv[3:0]});
        else          chk("R1 ff init", q_o, ~iv[7:0]);
      end
    end

    // R3, R4: sr encoding, sync vs async
    for (int syn = 0; syn < 2; syn++) begin
      for (int st = 0; st < 16; st++) begin
        for (int sv = 0; sv < 16; sv++) begin
          logic [3:0] ld;
          ld = ~(st[3:0] ^ sv[3:0]);
          do_init(mk(1'b0, syn[0], 1'b0, 1'b1, 1'b1, {st[3:0], st[3:0]},
                     {sv[3:0], sv[3:0]}, 8'h00, 4'h0, 4'h0));
          sr_i = 1'b1;
          #0.5;
          chk("R4 sr timing", q_o, (syn == 1) ? 8'hFF : {ld, ld});
          tick;
          chk("R3 sr load", q_o, {ld, ld});
          sr_i = 1'b0;
        end
      end
    end

    // R2: init beats async sr, then sr on next edge
    do_init(mk(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'hFF, 8'hFF, 8'hFF, 4'h0, 4'h0));
    pri_a_i = 4'h0; lut5_i = 4'h0;
    ginit_i = 1'b1; sr_i = 1'b1; ce_i = 1'b1;
    tick;
    chk("R2 init over sr", q_o, 8'h00);
    ginit_i = 1'b0;
    tick;
    chk("R2 sr after init", q_o, 8'hFF);
    sr_i = 1'b0;
    tick;
    chk("R2 data after sr", q_o, 8'h00);

    // R5: sr_used=0 ignores sr_i
    do_init(mk(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'hFF, 8'h00, 8'h00, 4'h0, 4'h0));
    sr_i = 1'b1; ce_i = 1'b1; pri_a_i = 4'h5; lut5_i = 4'hA;
    #0.5;
    chk("R5 no async sr", q_o, 8'hFF);
    tick;
    chk("R5 data despite sr", q_o, 8'hA5);
    sr_i = 1'b0;

    // R6: ce_used
    cfg_i = mk(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 4'h0, 4'h0);
    ce_i = 1'b0; pri_a_i = 4'h3; lut5_i = 4'hC;
    tick;
    chk("R6 ce forced", q_o, 8'hC3);
    cfg_i = mk(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00, 4'h0, 4'h0);
    pri_a_i = 4'h9; lut5_i = 4'h6;
    tick;
    chk("R6 ce hold", q_o, 8'hC3);
    tick;
    chk("R6 ce hold 2", q_o, 8'hC3);

    // R7: sync sr beats ce
    do_init(mk(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'h00, 8'hFF, 8'h00, 4'h0, 4'h0));
    sr_i = 1'b1; ce_i = 1'b1; pri_a_i = 4'hF; lut5_i = 4'hF;
    tick;
    chk("R7 sr over ce", q_o, 8'h00);
    sr_i = 1'b0;
    tick;
    chk("R7 data after sr", q_o, 8'hFF);

    // R11, R12: mux sweep
    ce_i = 1'b1;
    for (int ps = 0; ps < 16; ps++) begin
      for (int ss = 0; ss < 16; ss++) begin
        logic [3:0] ea, es;
        cfg_i = mk(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00, ss[3:0], ps[3:0]);
        pri_a_i = 4'h6 ^ ss[3:0];
        pri_b_i = 4'h3 ^ ps[3:0];
        lut5_i  = 4'h9 ^ ps[3:0];
        byp_i   = 4'hC ^ ss[3:0];
        ea = (ps[3:0] & pri_b_i) | (~ps[3:0] & pri_a_i);
        es = (ss[3:0] & byp_i) | (~ss[3:0] & lut5_i);
        tick;
        chk("R11/R12 mux", q_o, {es, ea});
      end
    end
    pri_b_i = '0; byp_i = '0;

    // R8: ff clock polarity
    do_init(mk(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00, 4'h0, 4'h0));
    ce_i = 1'b1; pri_a_i = 4'h0; lut5_i = 4'h0;
    #2;
    chk("R8 rise: no capture on fall", q_o, 8'hFF);
    #3;
    chk("R8 rise: capture", q_o, 8'h00);
    do_init(mk(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00, 4'h0, 4'h0));
    ce_i = 1'b1;
    #2;
    chk("R8 fall: capture", q_o, 8'h00);
    tick;

    // R9, R10: latch, gate high-active
    do_init(mk(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00, 4'h0, 4'h0));
    chk("R9 latch init", q_o, 8'h00);
    lut5_i = 4'hF;
    ce_i = 1'b1; pri_a_i = 4'hF;
    #0.5;
    chk("R9 transparent", q_o, 8'h0F);
    #2;
    pri_a_i = 4'h0;
    #0.5;
    chk("R9 closed gate hold", q_o, 8'h0F);
    tick;
    chk("R9 reopen", q_o, 8'h00);
    ce_i = 1'b0; pri_a_i = 4'h5;
    tick;
    chk("R9 ce low hold", q_o, 8'h00);

    // R9: latch, gate low-active
    do_init(mk(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00, 8'hFF, 4'h0, 4'h0));
    chk("R10 latch init", q_o, 8'h0F);
    ce_i = 1'b1; pri_a_i = 4'h0;
    #0.5;
    chk("R9 gate inactive high", q_o, 8'h0F);
    #2;
    chk("R9 gate active low", q_o, 8'h00);
    tick;

    finish_run;
  end
endmodule